// File: doc/BRIEF.md
# Vector element loop sequencer

This block steps a prefixed vector instruction through its elements one at a time. It acts as a small program counter inside a single instruction. It looks at the 32-bit prefix word to decide whether the instruction runs in prefixed vector mode. It keeps a 7-bit element step. From that step it forms the register numbers that the execute stage reads and writes for the current element. While elements remain, it keeps the next instruction address equal to the current one. When the loop ends, it lets the address move on by 8 for a prefixed instruction or by 4 for a plain one.

The execute stage presents the instruction's base register numbers and per-operand vector flags, together with the vector length. It raises `elem_done` for one cycle each time an element result is written. There is no data stream at this block's edge. `elem_done` is a plain control strobe with no back-pressure: every cycle in which it is high counts as one completed element. The address, register and write-enable outputs are combinational functions of the inputs and the step register. The step register is the block's only state.

Top module: `vec_elem_seq`

## Requirements
- R1: `is_prefixed` is 1 exactly when `prefix_word[31:26]` equals 6'b000001 and `prefix_word[24]` and `prefix_word[22]` are both 1. Bit 31 is the most significant bit.
- R2: When the current element is the last one, `next_pc` equals `cur_pc` + 8 if `is_prefixed` is 1 and `cur_pc` + 4 otherwise, modulo 2^64.
- R3: Source register number i is `src_base_flat[5i+4:5i]`. For each source, and likewise for the destination, the output register equals base + `step` modulo 32 when `is_prefixed` is 1 and the operand's vector flag is 1. Otherwise the output register equals the base unchanged.
- R4: When `is_prefixed` is 1, `dst_is_vec` is 1 and `step` + 1 < `vec_len`, the current element is not the last one. In that state `next_pc` equals `cur_pc`, and an `elem_done` cycle raises `step` by 1 at the clock edge.
- R5: When `dst_is_vec` is 0 or `is_prefixed` is 0, the current element is always the last one, even if `step` + 1 < `vec_len`. No later destination register is written.
- R6: An `elem_done` cycle on the last element sets `pc_advance` to 1 in that same cycle, and `step` returns to 0 at the clock edge. `pc_advance` is 0 in every cycle without `elem_done`.
- R7: With `vec_len` = 0, the first element is the last one: one element runs, then the PC advances with no step increment.
- R8: A synchronous active-high `rst` clears `step` to 0. Without reset, `step` changes only at an edge where `elem_done` is 1.
- R9: `dst_we` is 1 exactly in the cycles in which `elem_done` is 1.
- R10: Driving an element adder from the register outputs with VL=2, r5=0x4321, r6=0x2223, r9=0x1234, r10=0x1111 and destination base 1 gives the following results. With all operands vector: r1=0x5555 and r2=0x3334. With a scalar destination: r1=0x5555 and r2 left at 0. With a scalar first source: r1=0x5555 and r2=0x5432.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prefix_word | input | 32 | Prefix word of the current instruction |
| cur_pc | input | 64 | Current instruction address |
| vec_len | input | 7 | Vector length |
| src_base_flat | input | 15 | Three 5-bit source base registers, source 0 in the low bits |
| src_is_vec | input | 3 | Vector flag per source |
| dst_base | input | 5 | Destination base register |
| dst_is_vec | input | 1 | Destination vector flag |
| elem_done | input | 1 | Element completed this cycle |
| next_pc | output | 64 | Next instruction address |
| step | output | 7 | Current element step |
| src_reg_flat | output | 15 | Per-source register numbers for this element |
| dst_reg | output | 5 | Destination register number for this element |
| dst_we | output | 1 | Destination write enable |
| pc_advance | output | 1 | One-cycle pulse when the instruction completes |
| is_prefixed | output | 1 | Prefixed vector mode detected |

## Verification
The bench builds the block with its default parameters: three 5-bit sources, a 7-bit step and a 64-bit address. These values matter for two reasons. Vector lengths up to 127 exceed the 32-entry register space, so random loops reach the modulo-32 wraparound of register numbers. Random addresses near 2^64 reach the wrap of the address increment. Directed runs cover VL of 0 and 1, scalar and plain-mode early ends, and the three element-add cases, with a register-file model in the bench.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam logic [5:0] PFX_MAJOR = 6'b000001;
  localparam int PFX_MAJOR_HI = 31;
  localparam int PFX_FLAG_A = 24;
  localparam int PFX_FLAG_B = 22;
  localparam int INC_PREFIXED = 8;
  localparam int INC_PLAIN = 4;
endpackage

// File: rtl/vseq_prefix_detect.sv
module vseq_prefix_detect #(
  parameter int PW = 32
) (
  input  logic [PW-1:0] word,
  output logic          is_pfx
);
  import vseq_pkg::*;
  localparam int MAJ_LO = PFX_MAJOR_HI - 5;

  always_comb begin
    is_pfx = (word[PFX_MAJOR_HI:MAJ_LO] == PFX_MAJOR)
             && word[PFX_FLAG_A] && word[PFX_FLAG_B];
  end
endmodule

// File: rtl/vseq_step_ctr.sv
module vseq_step_ctr #(
  parameter int SW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_pfx,
  input  logic          dst_vec,
  input  logic [SW-1:0] vl,
  input  logic          done,
  output logic [SW-1:0] step,
  output logic          last
);
  localparam int XW = SW + 1;
  logic [XW-1:0] step_p1;
  logic [XW-1:0] vl_ext;

  always_comb begin
    step_p1 = {1'b0, step} + XW'(1);
    vl_ext  = {1'b0, vl};
    last    = !is_pfx || !dst_vec || (step_p1 >= vl_ext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step <= '0;
    end else if (done) begin
      if (last) step <= '0;
      else      step <= step_p1[SW-1:0];
    end
  end
endmodule

// File: rtl/vseq_reg_map.sv
module vseq_reg_map #(
  parameter int RW = 5,
  parameter int SW = 7,
  parameter int N  = 4
) (
  input  logic [N*RW-1:0] base_flat,
  input  logic [N-1:0]    is_vec,
  input  logic            is_pfx,
  input  logic [SW-1:0]   step,
  output logic [N*RW-1:0] reg_flat
);
  localparam int OW = (SW < RW) ? SW : RW;
  logic [RW-1:0] offs;

  always_comb begin
    offs = '0;
    offs[OW-1:0] = step[OW-1:0];
  end

  for (genvar i = 0; i < N; i++) begin : g_opnd
    always_comb begin
      if (is_pfx && is_vec[i])
        reg_flat[i*RW +: RW] = base_flat[i*RW +: RW] + offs;
      else
        reg_flat[i*RW +: RW] = base_flat[i*RW +: RW];
    end
  end
endmodule

// File: rtl/vseq_pc_next.sv
module vseq_pc_next #(
  parameter int PCW = 64
) (
  input  logic [PCW-1:0] cur_pc,
  input  logic           is_pfx,
  input  logic           hold,
  output logic [PCW-1:0] next_pc
);
  import vseq_pkg::*;
  logic [PCW-1:0] inc;

  always_comb begin
    inc = is_pfx ? PCW'(INC_PREFIXED) : PCW'(INC_PLAIN);
    next_pc = hold ? cur_pc : cur_pc + inc;
  end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int PW   = 32,
  parameter int PCW  = 64,
  parameter int SW   = 7,
  parameter int RW   = 5,
  parameter int NSRC = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PW-1:0]      prefix_word,
  input  logic [PCW-1:0]     cur_pc,
  input  logic [SW-1:0]      vec_len,
  input  logic [NSRC*RW-1:0] src_base_flat,
  input  logic [NSRC-1:0]    src_is_vec,
  input  logic [RW-1:0]      dst_base,
  input  logic               dst_is_vec,
  input  logic               elem_done,
  output logic [PCW-1:0]     next_pc,
  output logic [SW-1:0]      step,
  output logic [NSRC*RW-1:0] src_reg_flat,
  output logic [RW-1:0]      dst_reg,
  output logic               dst_we,
  output logic               pc_advance,
  output logic               is_prefixed
);
  localparam int NOP = NSRC + 1;

  logic                last_elem;
  logic [NOP*RW-1:0]   all_base;
  logic [NOP-1:0]      all_vec;
  logic [NOP*RW-1:0]   all_reg;

  vseq_prefix_detect #(.PW(PW)) u_detect (
    .word   (prefix_word),
    .is_pfx (is_prefixed)
  );

  vseq_step_ctr #(.SW(SW)) u_step (
    .clk     (clk),
    .rst     (rst),
    .is_pfx  (is_prefixed),
    .dst_vec (dst_is_vec),
    .vl      (vec_len),
    .done    (elem_done),
    .step    (step),
    .last    (last_elem)
  );

  always_comb begin
    all_base = {dst_base, src_base_flat};
    all_vec  = {dst_is_vec, src_is_vec};
  end

  vseq_reg_map #(.RW(RW), .SW(SW), .N(NOP)) u_regs (
    .base_flat (all_base),
    .is_vec    (all_vec),
    .is_pfx    (is_prefixed),
    .step      (step),
    .reg_flat  (all_reg)
  );

  always_comb begin
    src_reg_flat = all_reg[NSRC*RW-1:0];
    dst_reg      = all_reg[NOP*RW-1 -: RW];
    dst_we       = elem_done;
    pc_advance   = elem_done && last_elem;
  end

  vseq_pc_next #(.PCW(PCW)) u_pc (
    .cur_pc  (cur_pc),
    .is_pfx  (is_prefixed),
    .hold    (!last_elem),
    .next_pc (next_pc)
  );
endmodule

// File: rtl/vseq_checker.sv
module vseq_checker #(
  parameter int PCW = 64,
  parameter int SW  = 7
) (
  input logic           clk,
  input logic           rst,
  input logic [PCW-1:0] cur_pc,
  input logic [PCW-1:0] next_pc,
  input logic [SW-1:0]  step,
  input logic           dst_is_vec,
  input logic           elem_done,
  input logic           dst_we,
  input logic           pc_advance,
  input logic           is_prefixed
);
  assert_pc_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (elem_done && !pc_advance) |-> (next_pc == cur_pc));

  assert_step_inc_R4: assert property (@(posedge clk) disable iff (rst)
    (elem_done && !pc_advance) |=> (step == $past(step) + SW'(1)));

  assert_scalar_end_R5: assert property (@(posedge clk) disable iff (rst)
    (elem_done && !(is_prefixed && dst_is_vec)) |-> pc_advance);

  assert_step_clear_R6: assert property (@(posedge clk) disable iff (rst)
    pc_advance |=> (step == '0));

  assert_adv_needs_done_R6: assert property (@(posedge clk) disable iff (rst)
    !elem_done |-> !pc_advance);

  assert_pc_inc_R2: assert property (@(posedge clk) disable iff (rst)
    pc_advance |-> (next_pc == cur_pc + (is_prefixed ? PCW'(8) : PCW'(4))));

  assert_step_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !elem_done |=> $stable(step));

  assert_we_R9: assert property (@(posedge clk) disable iff (rst)
    dst_we == elem_done);
endmodule

bind vec_elem_seq vseq_checker #(.PCW(PCW), .SW(SW)) u_vseq_checker (
  .clk         (clk),
  .rst         (rst),
  .cur_pc      (cur_pc),
  .next_pc     (next_pc),
  .step        (step),
  .dst_is_vec  (dst_is_vec),
  .elem_done   (elem_done),
  .dst_we      (dst_we),
  .pc_advance  (pc_advance),
  .is_prefixed (is_prefixed)
);

// File: tb/vec_elem_seq_test.sv
module vec_elem_seq_test;
  localparam int RW = 5;
  localparam int NSRC = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] prefix_word;
  logic [63:0] cur_pc;
  logic [6:0]  vec_len;
  logic [14:0] src_base_flat;
  logic [2:0]  src_is_vec;
  logic [4:0]  dst_base;
  logic        dst_is_vec;
  logic        elem_done;
  logic [63:0] next_pc;
  logic [6:0]  step;
  logic [14:0] src_reg_flat;
  logic [4:0]  dst_reg;
  logic        dst_we;
  logic        pc_advance;
  logic        is_prefixed;

  int n_checks = 0;
  int n_fail = 0;
  logic [6:0] m_step = '0;
  logic [63:0] regs [32];

  localparam logic [31:0] PFX = 32'h0540_0000;

  always #4 clk = ~clk;

  vec_elem_seq uut (.*);

  function automatic bit f_pfx(logic [31:0] w);
    return (w[31:26] == 6'b000001) && w[24] && w[22];
  endfunction

  function automatic bit f_last(logic [31:0] w, logic dv, logic [6:0] vl, logic [6:0] s);
    return !f_pfx(w) || !dv || ({1'b0, s} + 8'd1 >= {1'b0, vl});
  endfunction

  function automatic logic [4:0] f_reg(logic [4:0] b, logic v, logic [31:0] w, logic [6:0] s);
    return (v && f_pfx(w)) ? b + s[4:0] : b;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all();
    bit lst;
    logic [63:0] epc;
    lst = f_last(prefix_word, dst_is_vec, vec_len, m_step);
    epc = lst ? cur_pc + (f_pfx(prefix_word) ? 64'd8 : 64'd4) : cur_pc;
    check(is_prefixed == f_pfx(prefix_word), "R1", 64'(is_prefixed), 64'(f_pfx(prefix_word)));
    check(step == m_step, "R8", 64'(step), 64'(m_step));
    check(next_pc == epc, lst ? "R2" : "R4", next_pc, epc);
    for (int i = 0; i < NSRC; i++) begin
      logic [4:0] e;
      e = f_reg(src_base_flat[i*RW +: RW], src_is_vec[i], prefix_word, m_step);
      check(src_reg_flat[i*RW +: RW] == e, "R3", 64'(src_reg_flat[i*RW +: RW]), 64'(e));
    end
    check(dst_reg == f_reg(dst_base, dst_is_vec, prefix_word, m_step), "R3",
          64'(dst_reg), 64'(f_reg(dst_base, dst_is_vec, prefix_word, m_step)));
    check(dst_we == elem_done, "R9", 64'(dst_we), 64'(elem_done));
    check(pc_advance == (elem_done && lst), lst ? "R6" : "R5",
          64'(pc_advance), 64'(elem_done && lst));
  endtask

  // One cycle: inputs already set after a negedge; check, then cross posedge.
  task automatic cycle();
    #1;
    check_all();
    @(posedge clk);
    if (elem_done) m_step = f_last(prefix_word, dst_is_vec, vec_len, m_step) ? 7'd0 : m_step + 7'd1;
    @(negedge clk);
  endtask

  task automatic run_case(bit dv, bit s0v, bit s1v, logic [63:0] e1, logic [63:0] e2, string tag);
    int guard;
    bit fin;
    for (int k = 0; k < 32; k++) regs[k] = '0;
    regs[5] = 64'h4321; regs[6] = 64'h2223; regs[9] = 64'h1234; regs[10] = 64'h1111;
    prefix_word = PFX; cur_pc = 64'h1000; vec_len = 7'd2;
    src_base_flat = {5'd0, 5'd9, 5'd5}; src_is_vec = {1'b0, s1v, s0v};
    dst_base = 5'd1; dst_is_vec = dv; elem_done = 1'b1;
    guard = 0; fin = 0;
    while (!fin && guard < 8) begin
      #1;
      if (dst_we) regs[dst_reg] = regs[src_reg_flat[4:0]] + regs[src_reg_flat[9:5]];
      fin = pc_advance;
      if (fin) check(next_pc == 64'h1008, "R2", next_pc, 64'h1008);
      #0 cycle();
      guard++;
    end
    check(regs[1] == e1, tag, regs[1], e1);
    check(regs[2] == e2, tag, regs[2], e2);
    elem_done = 1'b0;
  endtask

  initial begin
    #1600000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; prefix_word = PFX; cur_pc = 64'h200; vec_len = 7'd4;
    src_base_flat = '0; src_is_vec = '0; dst_base = '0; dst_is_vec = 1'b1; elem_done = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; elem_done = 1'b0;
    m_step = '0;
    #1 check(step == 7'd0, "R8", 64'(step), 64'd0);
    @(negedge clk);

    // R10 directed element-add cases
    run_case(1'b1, 1'b1, 1'b1, 64'h5555, 64'h3334, "R10");
    run_case(1'b0, 1'b1, 1'b1, 64'h5555, 64'h0, "R10");
    run_case(1'b1, 1'b0, 1'b1, 64'h5555, 64'h5432, "R10");

    // R7: VL=0, one element then advance
    prefix_word = PFX; vec_len = 7'd0; dst_is_vec = 1'b1; elem_done = 1'b1;
    cur_pc = 64'hFFFF_FFFF_FFFF_FFFC;
    #1 check(pc_advance == 1'b1, "R7", 64'(pc_advance), 64'd1);
    check(next_pc == 64'h4, "R7", next_pc, 64'h4);
    #0 cycle();
    check(step == 7'd0, "R7", 64'(step), 64'd0);

    // R5: plain instruction with vector flags set advances by 4
    prefix_word = 32'h0500_0000; vec_len = 7'd9; cur_pc = 64'h40;
    #1 check(next_pc == 64'h44, "R5", next_pc, 64'h44);
    #0 cycle();

    // R8: step frozen when no strobe
    prefix_word = PFX; vec_len = 7'd40; dst_base = 5'd30; elem_done = 1'b1;
    cycle(); cycle();
    elem_done = 1'b0;
    for (int k = 0; k < 3; k++) cycle();

    // random
    for (int it = 0; it < 3000; it++) begin
      if (m_step == 0 || ($urandom % 16) == 0) begin
        logic [31:0] w;
        w = $urandom;
        if ($urandom % 4 != 0) begin w[31:26] = 6'b000001; w[24] = 1'b1; w[22] = 1'b1; end
        prefix_word = w;
        cur_pc = {$urandom, $urandom};
        vec_len = ($urandom % 4 == 0) ? 7'($urandom) : 7'($urandom % 6);
        src_base_flat = 15'($urandom);
        src_is_vec = 3'($urandom);
        dst_base = 5'($urandom);
        dst_is_vec = ($urandom % 5) != 0;
      end
      elem_done = ($urandom % 3) != 0;
      cycle();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule